// File: doc/BRIEF.md
# DMA Channel Configuration Register Bank

This block holds the software-visible setup of eight DMA channels and the two global enable registers that arm them. A byte-wide register bus (16-bit address, separate write and read strobes) reaches a 128-byte window starting at 0x4300. Address bits 6:4 pick the channel and bits 3:0 pick a byte slot inside it. Each channel keeps twelve bytes: a control byte, a peripheral-side address, a 16-bit memory address with its bank, a 16-bit word that serves as either the transfer count or the indirect pointer, an indirect bank, a 16-bit table pointer, a line counter and one spare byte. The transfer engine reads these bytes elsewhere and is not part of this block.

Slot 0xF is a second name for the spare byte at slot 0xB. Slots 0xC to 0xE hold nothing: writes to them are dropped and reads return the open-bus byte, which is the last byte that crossed the data bus in either direction. A read of any address this block does not own also returns the open-bus byte.

Two addresses outside the window load the per-channel enable vectors. A nonzero write to the normal-transfer enable register also raises a pending flag, which the transfer engine drops with a one-cycle acknowledge.

Top module: `dma_cfg_bank`

## Requirements
- R1: After a synchronous reset every channel byte reads 0xFF, both enable vectors and the pending flag are 0, and the read data and open-bus byte are 0x00.
- R2: A write to 0x43CS (C = channel 0..7 in address bits 6:4, S = slot 0x0..0xB in bits 3:0) stores all eight data bits, including the unused control bit 5; a read of the same address returns them on `rd_data` in the cycle after `rd_en`, and no other channel or slot changes.
- R3: Slots 2/3, 5/6 and 8/9 are low/high bytes of 16-bit fields; writing one byte leaves the other byte of the pair unchanged.
- R4: Writes to slots 0xC, 0xD and 0xE change no stored byte, and reads of them return the open-bus byte.
- R5: Slot 0xF reads and writes the same storage as slot 0xB of the same channel.
- R6: A write to address 0x420B loads the normal-transfer enable vector, channel i from data bit i; any nonzero data byte sets the pending flag, and a zero byte leaves it as it was.
- R7: A write to address 0x420C loads the table-transfer enable vector from the data bits and does not alter the pending flag.
- R8: A pulse on `pend_ack` clears the pending flag; when it coincides with a nonzero write to 0x420B, the flag is set.
- R9: The open-bus byte takes the data of every write (any address) and of every read; reads outside the window return it, and writes outside the window change no channel byte.
- R10: `rd_data` holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Register byte address |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| pend_ack | input | 1 | Transfer engine acknowledge, clears the pending flag |
| dma_en | output | 8 | Normal-transfer enable per channel |
| hdma_en | output | 8 | Table-transfer enable per channel |
| dma_pending | output | 1 | A normal transfer has been requested |

## Verification
The pending flag has two sources that can meet in one cycle: a nonzero write to the normal-transfer enable register sets it, and the engine's acknowledge clears it. The bench drives the acknowledge pulse in the very cycle of a nonzero enable write and expects the flag to read 1 afterwards, then pulses the acknowledge alone and expects 0; a zero-valued enable write coinciding with nothing must leave a set flag standing. The open-bus byte is the other shared point, since a write and the following read of an unmapped slot both touch it, and the bench tracks it with its own model through every access of the sweep.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int NUM_SLOTS = 12;
  localparam int SLOT_W    = 4;
  localparam logic [SLOT_W-1:0] SLOT_SPARE = 4'hB;
  localparam logic [SLOT_W-1:0] SLOT_ALIAS = 4'hF;
  localparam logic [7:0] CH_RESET_BYTE = 8'hFF;

  typedef struct packed {
    logic              in_win;
    logic              mapped;
    logic [SLOT_W-1:0] slot;
  } reg_sel_t;
endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
  import dma_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          CH_W     = 3,
  parameter logic [15:0] WIN_BASE = 16'h4300
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic [CH_W-1:0]   chan
);
  localparam int LO = CH_W + SLOT_W;

  logic [SLOT_W-1:0] off;

  always_comb begin
    off        = addr[SLOT_W-1:0];
    chan       = addr[LO-1:SLOT_W];
    sel.in_win = (addr[ADDR_W-1:LO] == WIN_BASE[ADDR_W-1:LO]);
    if (off == SLOT_ALIAS) begin
      sel.slot   = SLOT_SPARE;
      sel.mapped = sel.in_win;
    end else if (off <= SLOT_SPARE) begin
      sel.slot   = off;
      sel.mapped = sel.in_win;
    end else begin
      sel.slot   = '0;
      sel.mapped = 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_cfg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CH_W-1:0]   chan,
  input  logic [SLOT_W-1:0] slot,
  input  logic [7:0]        wdata,
  output logic [7:0]        rbyte
);
  logic [7:0] ch_rd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [7:0] bytes_q [NUM_SLOTS];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < NUM_SLOTS; s++) bytes_q[s] <= CH_RESET_BYTE;
      end else if (we && chan == CH_W'(c)) begin
        bytes_q[slot] <= wdata;
      end
    end
    assign ch_rd[c] = bytes_q[slot];
  end

  assign rbyte = ch_rd[chan];
endmodule

// File: rtl/dma_enable_ctl.sv
module dma_enable_ctl #(
  parameter int          NUM_CH       = 8,
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] DMA_EN_ADDR  = 16'h420B,
  parameter logic [15:0] HDMA_EN_ADDR = 16'h420C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              ack,
  output logic [NUM_CH-1:0] dma_en,
  output logic [NUM_CH-1:0] hdma_en,
  output logic              pending
);
  logic dma_wr, hdma_wr;
  assign dma_wr  = wr_en && (addr == DMA_EN_ADDR[ADDR_W-1:0]);
  assign hdma_wr = wr_en && (addr == HDMA_EN_ADDR[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_en  <= '0;
      hdma_en <= '0;
      pending <= 1'b0;
    end else begin
      if (dma_wr)  dma_en  <= wdata[NUM_CH-1:0];
      if (hdma_wr) hdma_en <= wdata[NUM_CH-1:0];
      if (dma_wr && (|wdata)) pending <= 1'b1;
      else if (ack)           pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_cfg_bank.sv
module dma_cfg_bank
  import dma_cfg_pkg::*;
#(
  parameter int          NUM_CH       = 8,
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] WIN_BASE     = 16'h4300,
  parameter logic [15:0] DMA_EN_ADDR  = 16'h420B,
  parameter logic [15:0] HDMA_EN_ADDR = 16'h420C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              pend_ack,
  output logic [NUM_CH-1:0] dma_en,
  output logic [NUM_CH-1:0] hdma_en,
  output logic              dma_pending
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_sel_t        sel;
  logic [CH_W-1:0] chan;
  logic [7:0]      stored_byte;
  logic [7:0]      rd_val;
  logic [7:0]      open_bus_q;

  dma_addr_decode #(.ADDR_W(ADDR_W), .CH_W(CH_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr (addr),
    .sel  (sel),
    .chan (chan)
  );

  dma_chan_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en && sel.mapped),
    .chan  (chan),
    .slot  (sel.slot),
    .wdata (wr_data),
    .rbyte (stored_byte)
  );

  dma_enable_ctl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
    .DMA_EN_ADDR(DMA_EN_ADDR), .HDMA_EN_ADDR(HDMA_EN_ADDR)
  ) u_en (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wr_data),
    .ack     (pend_ack),
    .dma_en  (dma_en),
    .hdma_en (hdma_en),
    .pending (dma_pending)
  );

  assign rd_val = sel.mapped ? stored_byte : open_bus_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= 8'h00;
      open_bus_q <= 8'h00;
    end else begin
      if (rd_en) rd_data <= rd_val;
      if (wr_en)      open_bus_q <= wr_data;
      else if (rd_en) open_bus_q <= rd_val;
    end
  end
endmodule

// File: rtl/dma_cfg_bank_chk.sv
module dma_cfg_bank_chk #(
  parameter int          NUM_CH       = 8,
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] DMA_EN_ADDR  = 16'h420B,
  parameter logic [15:0] HDMA_EN_ADDR = 16'h420C
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              pend_ack,
  input logic [NUM_CH-1:0] dma_en,
  input logic [NUM_CH-1:0] hdma_en,
  input logic              dma_pending
);
  logic dma_wr, hdma_wr;
  assign dma_wr  = wr_en && (addr == DMA_EN_ADDR[ADDR_W-1:0]);
  assign hdma_wr = wr_en && (addr == HDMA_EN_ADDR[ADDR_W-1:0]);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dma_en == '0 && hdma_en == '0 && !dma_pending && rd_data == 8'h00));

  // R6
  dma_load_chk: assert property (@(posedge clk) disable iff (rst)
    dma_wr |=> (dma_en == $past(wr_data[NUM_CH-1:0])));

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_wr && wr_data != 8'h00) |=> dma_pending);

  // R7
  hdma_load_chk: assert property (@(posedge clk) disable iff (rst)
    hdma_wr |=> (hdma_en == $past(wr_data[NUM_CH-1:0])));

  // R7
  hdma_pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hdma_wr && !pend_ack) |=> (dma_pending == $past(dma_pending)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_ack && !(dma_wr && wr_data != 8'h00)) |=> !dma_pending);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$fell(rst)) |=> $stable(rd_data));
endmodule

bind dma_cfg_bank dma_cfg_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
  .DMA_EN_ADDR(DMA_EN_ADDR), .HDMA_EN_ADDR(HDMA_EN_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .pend_ack(pend_ack),
  .dma_en(dma_en), .hdma_en(hdma_en), .dma_pending(dma_pending)
);

// File: tb/tb_dma_cfg_bank.sv
module tb_dma_cfg_bank;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        pend_ack = 1'b0;
  logic [7:0]  dma_en, hdma_en;
  logic        dma_pending;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [8][12];
  logic [7:0] ob;

  always #(CLK_NS/2) clk = ~clk;

  dma_cfg_bank dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .pend_ack(pend_ack),
    .dma_en(dma_en), .hdma_en(hdma_en), .dma_pending(dma_pending)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic ack = 1'b0);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; pend_ack = ack;
    @(negedge clk);
    wr_en = 1'b0; pend_ack = 1'b0;
    ob = d;
    if (a[15:7] == 9'h086 && (a[3:0] <= 4'hB || a[3:0] == 4'hF))
      model[a[6:4]][(a[3:0] == 4'hF) ? 4'hB : a[3:0]] = d;
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    logic [7:0] exp;
    if (a[15:7] == 9'h086 && a[3:0] <= 4'hB)  exp = model[a[6:4]][a[3:0]];
    else if (a[15:7] == 9'h086 && a[3:0] == 4'hF) exp = model[a[6:4]][11];
    else exp = ob;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
    ob = exp;
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 12; s++) model[c][s] = 8'hFF;
    ob = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state of outputs and open-bus byte
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 dma_en", dma_en, 8'h00);
    chk("R1 hdma_en", hdma_en, 8'h00);
    chk("R1 pending", {7'd0, dma_pending}, 8'h00);
    rd(16'h430C, "R1 open bus after reset");
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 12; s++)
        rd(16'h4300 | 16'(c << 4) | 16'(s), "R1 channel byte reset");

    // R2 sweep: unique byte per channel/slot, then full readback incl. R4/R5
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 12; s++)
        wr(16'h4300 | 16'(c << 4) | 16'(s), 8'((c * 37 + s * 11 + 5) ^ 8'h20));
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 16; s++)
        rd(16'h4300 | 16'(c << 4) | 16'(s), "R2/R4/R5 sweep readback");

    // R10 rd_data holds across idle and write cycles
    begin
      logic [7:0] held;
      held = rd_data;
      repeat (3) @(negedge clk);
      chk("R10 hold idle", rd_data, held);
      wr(16'h4371, 8'h3C);
      chk("R10 hold over write", rd_data, held);
    end

    // R3 byte pairs independent
    wr(16'h4322, 8'hC3);
    rd(16'h4323, "R3 high kept");
    rd(16'h4322, "R3 low written");
    wr(16'h4356, 8'h4E);
    rd(16'h4355, "R3 low kept");
    wr(16'h4619, 8'h00);
    wr(16'h4319, 8'hB0);
    rd(16'h4318, "R3 table low kept");
    rd(16'h4319, "R3 table high written");

    // R4 unmapped slots drop writes and return open bus
    wr(16'h430D, 8'h77);
    rd(16'h430D, "R4 unmapped returns written byte as open bus");
    rd(16'h430B, "R4 spare untouched");
    rd(16'h430C, "R4 open bus follows last read");
    wr(16'h43EE, 8'h12);
    rd(16'h436E, "R4 slot E open bus");

    // R5 alias both directions
    wr(16'h434F, 8'h9E);
    rd(16'h434B, "R5 alias write seen at spare");
    wr(16'h434B, 8'h17);
    rd(16'h434F, "R5 spare write seen at alias");
    rd(16'h433B, "R5 other channel untouched");

    // R9 open bus and outside window
    wr(16'h2000, 8'h6D);
    rd(16'h2001, "R9 outside read returns last write");
    rd(16'h4380, "R9 window edge is outside");
    wr(16'h4380, 8'h33);
    rd(16'h4300, "R9 outside write leaves channel 0");
    rd(16'h42FF, "R9 open bus took read byte");

    // R6 normal-transfer enable and pending
    wr(16'h420B, 8'h00);
    chk("R6 zero write enables", dma_en, 8'h00);
    chk("R6 zero write no pending", {7'd0, dma_pending}, 8'h00);
    wr(16'h420B, 8'h5A);
    chk("R6 enable vector", dma_en, 8'h5A);
    chk("R6 pending set", {7'd0, dma_pending}, 8'h01);
    wr(16'h420B, 8'h00);
    chk("R6 zero write clears enables", dma_en, 8'h00);
    chk("R6 zero write keeps pending", {7'd0, dma_pending}, 8'h01);

    // R7 table-transfer enable leaves pending
    wr(16'h420C, 8'h81);
    chk("R7 hdma vector", hdma_en, 8'h81);
    chk("R7 pending unchanged", {7'd0, dma_pending}, 8'h01);

    // R8 ack clears, set wins on collision
    @(negedge clk); pend_ack = 1'b1;
    @(negedge clk); pend_ack = 1'b0;
    chk("R8 ack clears", {7'd0, dma_pending}, 8'h00);
    wr(16'h420C, 8'h00);
    chk("R7 hdma cleared", hdma_en, 8'h00);
    chk("R7 pending stays clear", {7'd0, dma_pending}, 8'h00);
    wr(16'h420B, 8'h01, 1'b1);
    chk("R8 set wins over ack", {7'd0, dma_pending}, 8'h01);
    chk("R8 enable loaded with ack", dma_en, 8'h01);
    wr(16'h420B, 8'h80, 1'b0);
    chk("R6 channel 7 bit", dma_en, 8'h80);
    @(negedge clk); pend_ack = 1'b1;
    @(negedge clk); pend_ack = 1'b0;
    chk("R8 ack clears again", {7'd0, dma_pending}, 8'h00);
    chk("R8 ack leaves enables", dma_en, 8'h80);

    // R1 re-reset restores bytes
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 12; s++) model[c][s] = 8'hFF;
    ob = 8'h00;
    chk("R1 second reset dma_en", dma_en, 8'h00);
    rd(16'h430E, "R1 second reset open bus");
    rd(16'h4375, "R1 second reset channel byte");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule